// File: doc/BRIEF.md
# Gated Serial Bus Byte Sniffer

This block listens, without driving anything, to a clocked three-wire bus of the kind found between car-audio units: a bus clock, an active-low data line, a bus reset line and a power-on qualifier. It collects the data bits into bytes and hands each finished byte, already bit-inverted back to true polarity, to a downstream asynchronous serial transmitter through a one-cycle valid strobe.

Capture is gated. The block first waits for the bus reset line to be low, then for the power qualifier to be high, then for the bus clock to be seen at its idle low level. Only then does it arm its shifter, so that it never begins in the middle of a clock pulse. While armed, a bus reset going high or the power qualifier going low disarms it at once, throws away any partial byte and sends it back to the first waiting step. All bus inputs are brought into the system clock domain through two-flop synchronizers and bus clock edges are found on the synchronized copy. If a byte completes while the transmitter still reports busy, the new byte is delivered anyway and a sticky overrun flag is raised until the next restart.

Top module: `bus_byte_sniffer`

## Requirements
- R1: Each byte completes on the rising bus clock edge of its eighth bit; `out_valid` is high for exactly one system clock cycle, the third rising system clock edge after `bus_clk` rises at the pin.
- R2: Bits are sampled from `bus_data` on rising bus clock edges, the first bit of a byte becoming bit 7 of the result and the eighth bit becoming bit 0.
- R3: `out_byte` is the bitwise inverse of the eight sampled data levels (a wire pattern of 8'hA5 yields 8'h5A) and holds its value until the next byte completes.
- R4: The block stays disarmed (`armed` low) while the synchronized `bus_rst` is high, and after it goes low stays disarmed until `bus_pwr` is high.
- R5: With reset low and power high, the block arms only after the synchronized `bus_clk` is sampled low; while `bus_clk` is held high it stays disarmed.
- R6: While armed, `bus_rst` going high or `bus_pwr` going low drops `armed` within four system clock cycles and discards the partial byte, so the next byte after re-arming is assembled from its own eight bits only.
- R7: A byte completing while `tx_busy` is high is still delivered and sets `overrun`; `overrun` stays set across later bytes and is cleared when the block disarms.
- R8: A synchronous active-high `rst` disarms the block from the next clock edge, clears the bit count, `out_valid` and `overrun`.
- R9: While disarmed, bus clock edges produce no `out_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| bus_clk | input | 1 | Bus clock, idle low, asynchronous |
| bus_data | input | 1 | Bus data line, active low, asynchronous |
| bus_rst | input | 1 | Bus reset line, high holds the block idle |
| bus_pwr | input | 1 | Bus power-on qualifier, high when powered |
| tx_busy | input | 1 | Downstream transmitter still sending |
| out_valid | output | 1 | One-cycle strobe for a completed byte |
| out_byte | output | 8 | Completed byte, true polarity |
| overrun | output | 1 | Sticky flag: byte completed while transmitter busy |
| armed | output | 1 | Shifter enabled and capturing |

## Verification
Every bus input crosses two synchronizer flops, so a level changed at the pins on a falling system clock edge is visible to the control logic after two rising edges; the byte strobe is registered once more and is due on the third rising edge after the final `bus_clk` rise. The bench changes pins only on falling edges and, for the last bit of every byte, samples on the falling edges after the second, third and fourth rising edges, expecting low, high with the byte, then low again. Arming takes up to five rising edges after the qualifiers settle and disarming up to three, so those checks sample after eight and four cycles respectively, beyond the latest due point.

// File: rtl/sniff_pkg.sv
package sniff_pkg;

    typedef enum logic [1:0] {
        ST_WAIT_RST_LOW = 2'd0,
        ST_WAIT_PWR     = 2'd1,
        ST_WAIT_CLK_LOW = 2'd2,
        ST_CAPTURE      = 2'd3
    } arm_state_e;

    localparam int unsigned SYNC_BITS = 4;
    localparam int unsigned SB_CLK  = 3;
    localparam int unsigned SB_DATA = 2;
    localparam int unsigned SB_RST  = 1;
    localparam int unsigned SB_PWR  = 0;

endpackage

// File: rtl/sniff_sync.sv
module sniff_sync #(
    parameter int unsigned            WIDTH   = 4,
    parameter int unsigned            STAGES  = 2,
    parameter logic [WIDTH-1:0]       RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_bit
        logic [STAGES-1:0] chain_d;
        logic [STAGES-1:0] chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], async_in[gi]};
        end

        always_ff @(posedge clk) begin
            if (rst) chain_q <= {STAGES{RST_VAL[gi]}};
            else     chain_q <= chain_d;
        end

        assign sync_out[gi] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/sniff_ctrl.sv
module sniff_ctrl
    import sniff_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bus_rst_s,
    input  logic bus_pwr_s,
    input  logic bus_clk_s,
    output logic armed
);

    typedef struct packed {
        arm_state_e state;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;
    logic  qual_lost;

    always_comb begin
        qual_lost = bus_rst_s || !bus_pwr_s;
        ctrl_d    = ctrl_q;
        unique case (ctrl_q.state)
            ST_WAIT_RST_LOW: begin
                if (!bus_rst_s) ctrl_d.state = ST_WAIT_PWR;
            end
            ST_WAIT_PWR: begin
                if (bus_rst_s)      ctrl_d.state = ST_WAIT_RST_LOW;
                else if (bus_pwr_s) ctrl_d.state = ST_WAIT_CLK_LOW;
            end
            ST_WAIT_CLK_LOW: begin
                if (qual_lost)       ctrl_d.state = ST_WAIT_RST_LOW;
                else if (!bus_clk_s) ctrl_d.state = ST_CAPTURE;
            end
            ST_CAPTURE: begin
                if (qual_lost) ctrl_d.state = ST_WAIT_RST_LOW;
            end
            default: ctrl_d.state = ST_WAIT_RST_LOW;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ctrl_q.state <= ST_WAIT_RST_LOW;
        else     ctrl_q       <= ctrl_d;
    end

    assign armed = (ctrl_q.state == ST_CAPTURE);

    assert_abort_on_qual_R6: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.state == ST_CAPTURE && (bus_rst_s || !bus_pwr_s))
            |=> (ctrl_q.state == ST_WAIT_RST_LOW));

    assert_arm_after_clk_low_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(armed) |-> $past(!bus_clk_s));

    assert_no_arm_in_reset_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(armed) |-> $past(!bus_rst_s && bus_pwr_s));

    assert_sys_reset_idle_R8: assert property (@(posedge clk)
        rst |=> (ctrl_q.state == ST_WAIT_RST_LOW));

endmodule

// File: rtl/sniff_shifter.sv
module sniff_shifter #(
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              bus_clk_s,
    input  logic              bus_data_s,
    input  logic              tx_busy,
    output logic              byte_valid,
    output logic [BYTE_W-1:0] byte_out,
    output logic              overrun
);

    localparam int unsigned CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    typedef struct packed {
        logic [BYTE_W-1:0] shreg;
        logic [CNT_W-1:0]  cnt;
        logic              prev_clk;
        logic              valid;
        logic [BYTE_W-1:0] data;
        logic              ovr;
    } shift_t;

    shift_t            sh_d, sh_q;
    logic              rise;
    logic [BYTE_W-1:0] assembled;

    always_comb begin
        rise      = bus_clk_s && !sh_q.prev_clk;
        assembled = {sh_q.shreg[BYTE_W-2:0], bus_data_s};
        sh_d          = sh_q;
        sh_d.prev_clk = bus_clk_s;
        sh_d.valid    = 1'b0;
        if (!enable) begin
            sh_d.shreg = '0;
            sh_d.cnt   = '0;
            sh_d.ovr   = 1'b0;
        end else if (rise) begin
            sh_d.shreg = assembled;
            if (sh_q.cnt == LAST_BIT) begin
                sh_d.cnt   = '0;
                sh_d.valid = 1'b1;
                sh_d.data  = ~assembled;
                if (tx_busy) sh_d.ovr = 1'b1;
            end else begin
                sh_d.cnt = sh_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q.shreg    <= '0;
            sh_q.cnt      <= '0;
            sh_q.prev_clk <= 1'b0;
            sh_q.valid    <= 1'b0;
            sh_q.data     <= '0;
            sh_q.ovr      <= 1'b0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign byte_valid = sh_q.valid;
    assign byte_out   = sh_q.data;
    assign overrun    = sh_q.ovr;

    assert_count_cleared_R6: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (sh_q.cnt == '0));

    assert_overrun_cause_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun) |-> ($past(tx_busy) && byte_valid));

    assert_valid_one_cycle_R1: assert property (@(posedge clk) disable iff (rst)
        byte_valid |=> !byte_valid);

    assert_data_stable_R3: assert property (@(posedge clk) disable iff (rst)
        !byte_valid |-> $stable(byte_out));

endmodule

// File: rtl/bus_byte_sniffer.sv
module bus_byte_sniffer
    import sniff_pkg::*;
#(
    parameter int unsigned BYTE_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_clk,
    input  logic              bus_data,
    input  logic              bus_rst,
    input  logic              bus_pwr,
    input  logic              tx_busy,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_byte,
    output logic              overrun,
    output logic              armed
);

    localparam logic [SYNC_BITS-1:0] SYNC_RST = SYNC_BITS'(1) << SB_RST;

    logic [SYNC_BITS-1:0] raw_w;
    logic [SYNC_BITS-1:0] sync_w;
    logic                 armed_w;

    always_comb begin
        raw_w         = '0;
        raw_w[SB_CLK]  = bus_clk;
        raw_w[SB_DATA] = bus_data;
        raw_w[SB_RST]  = bus_rst;
        raw_w[SB_PWR]  = bus_pwr;
    end

    sniff_sync #(
        .WIDTH   (SYNC_BITS),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (raw_w),
        .sync_out (sync_w)
    );

    sniff_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .bus_rst_s (sync_w[SB_RST]),
        .bus_pwr_s (sync_w[SB_PWR]),
        .bus_clk_s (sync_w[SB_CLK]),
        .armed     (armed_w)
    );

    sniff_shifter #(
        .BYTE_W (BYTE_W)
    ) u_shift (
        .clk        (clk),
        .rst        (rst),
        .enable     (armed_w),
        .bus_clk_s  (sync_w[SB_CLK]),
        .bus_data_s (sync_w[SB_DATA]),
        .tx_busy    (tx_busy),
        .byte_valid (out_valid),
        .byte_out   (out_byte),
        .overrun    (overrun)
    );

    assign armed = armed_w;

    assert_valid_needs_arm_R9: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(armed_w));

endmodule

// File: tb/bus_byte_sniffer_bench.sv
module bus_byte_sniffer_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       bus_clk, bus_data, bus_rst, bus_pwr, tx_busy;
    logic       out_valid;
    logic [7:0] out_byte;
    logic       overrun;
    logic       armed;

    int n_checks = 0;
    int n_fails  = 0;
    int n_valid  = 0;
    bit finished = 1'b0;
    bit ovr_exp  = 1'b0;

    // {busy, wire pattern, expected byte}
    localparam int NV = 7;
    localparam logic [16:0] VEC [NV] = '{
        {1'b0, 8'h00, 8'hFF},
        {1'b0, 8'hFF, 8'h00},
        {1'b0, 8'hA5, 8'h5A},
        {1'b0, 8'h01, 8'hFE},
        {1'b1, 8'h3C, 8'hC3},
        {1'b0, 8'h80, 8'h7F},
        {1'b0, 8'h96, 8'h69}
    };

    always #5 clk = ~clk;

    bus_byte_sniffer u_bus_byte_sniffer (
        .clk       (clk),
        .rst       (rst),
        .bus_clk   (bus_clk),
        .bus_data  (bus_data),
        .bus_rst   (bus_rst),
        .bus_pwr   (bus_pwr),
        .tx_busy   (tx_busy),
        .out_valid (out_valid),
        .out_byte  (out_byte),
        .overrun   (overrun),
        .armed     (armed)
    );

    always @(negedge clk) if (out_valid) n_valid++;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Sends nbits of pattern MSB first; when full, checks the strobe timing.
    task automatic send_bits(input logic [7:0] pat, input int nbits, input bit full,
                             input logic [7:0] exp);
        for (int i = 0; i < nbits; i++) begin
            bus_data = pat[7-i];
            tick(2);
            bus_clk = 1'b1;
            if (full && i == nbits - 1) begin
                tick(2);
                check("R1 strobe not early", int'(out_valid), 0);
                tick(1);
                check("R1 strobe due", int'(out_valid), 1);
                check("R2/R3 byte value", int'(out_byte), int'(exp));
                tick(1);
                check("R1 strobe single cycle", int'(out_valid), 0);
                tick(1);
            end else begin
                tick(4);
            end
            bus_clk = 1'b0;
            tick(4);
        end
    endtask

    task automatic arm_bus();
        bus_clk = 1'b0;
        bus_rst = 1'b0;
        bus_pwr = 1'b1;
        tick(8);
    endtask

    initial begin
        #1_500_000;
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; bus_clk = 1'b0; bus_data = 1'b1;
        bus_rst = 1'b1; bus_pwr = 1'b0; tx_busy = 1'b0;
        tick(3);
        rst = 1'b0;
        tick(1);
        // R8 reset state
        check("R8 armed after reset", int'(armed), 0);
        check("R8 valid after reset", int'(out_valid), 0);
        check("R8 overrun after reset", int'(overrun), 0);

        // R4: bus held in reset keeps idle, even with power
        bus_pwr = 1'b1;
        tick(10);
        check("R4 idle while bus_rst high", int'(armed), 0);
        // R9: clock edges while disarmed give no strobe
        for (int i = 0; i < 16; i++) begin
            bus_data = i[0];
            bus_clk = 1'b1; tick(4);
            bus_clk = 1'b0; tick(4);
        end
        check("R9 no strobe while disarmed", n_valid, 0);
        bus_rst = 1'b0; bus_pwr = 1'b0;
        tick(10);
        check("R4 waits for power", int'(armed), 0);
        bus_pwr = 1'b1;
        tick(8);
        check("R4 arms with power", int'(armed), 1);

        // vector table
        for (int v = 0; v < NV; v++) begin
            tx_busy = VEC[v][16];
            send_bits(VEC[v][15:8], 8, 1'b1, VEC[v][7:0]);
            tx_busy = 1'b0;
            ovr_exp = ovr_exp | VEC[v][16];
            check("R7 overrun sticky", int'(overrun), int'(ovr_exp));
        end
        check("R1 one strobe per byte", n_valid, NV);

        // R7/R6: restart clears overrun
        bus_rst = 1'b1;
        tick(4);
        check("R6 disarm on bus_rst", int'(armed), 0);
        check("R7 overrun cleared on restart", int'(overrun), 0);

        // R5: clock held high blocks arming
        bus_clk = 1'b1;
        bus_rst = 1'b0;
        tick(12);
        check("R5 no arm with clock high", int'(armed), 0);
        bus_clk = 1'b0;
        tick(8);
        check("R5 arms after clock low", int'(armed), 1);

        // R6: partial byte then bus reset, partial discarded
        send_bits(8'hFF, 3, 1'b0, 8'h00);
        bus_rst = 1'b1;
        tick(4);
        check("R6 disarm mid byte", int'(armed), 0);
        arm_bus();
        send_bits(8'h5A, 8, 1'b1, 8'hA5);

        // R6: partial byte then power drop
        send_bits(8'h00, 5, 1'b0, 8'h00);
        bus_pwr = 1'b0;
        tick(4);
        check("R6 disarm on power drop", int'(armed), 0);
        arm_bus();
        check("R6 rearm after power", int'(armed), 1);
        send_bits(8'hC3, 8, 1'b1, 8'h3C);

        // R8: system reset mid byte clears count
        send_bits(8'hFF, 4, 1'b0, 8'h00);
        rst = 1'b1;
        tick(1);
        check("R8 disarm on system reset", int'(armed), 0);
        tick(1);
        rst = 1'b0;
        tick(8);
        check("R8 rearm after system reset", int'(armed), 1);
        send_bits(8'h0F, 8, 1'b1, 8'hF0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule